// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate

This block sits between a free-running source clock (typically the output of a clock divider) and an output pin, and decides when that clock may reach the pin. After the power-good reset is released, the gate keeps the pin low until a fixed number of source cycles has passed. After that, an output-enable control and a power-down control open and close the gate. The gate only changes state while the source clock is low, so every pulse that reaches the pin is a complete high phase of the source.

Both controls are asynchronous to the source clock and pass through a two-flop synchronizer. The power-down control is also filtered: a request takes effect only after the synchronized level has been high for a minimum number of consecutive source edges. That minimum is two output periods plus a deglitch interval set by a parameter. When power-down is released, the start-up count runs again from zero before the output can restart. A status output reports whether pulses are currently passing.

Top module: `glitchfree_clk_gate`

## Requirements
- R1: While `rst_n` is low, `clk_out` and `running` are both low.
- R2: After `rst_n` rises, `clk_out` stays low through the first START_CYC (default 512) rising edges of `src_clk`. `running` rises on the falling edge that follows edge START_CYC, and the first output pulse comes at edge START_CYC+1. This assumes `oe_in` is high and `pd_in` is low.
- R3: When `oe_in` is low for more than three source cycles, `clk_out` and `running` go low. When `oe_in` returns high, the output resumes within three cycles, provided start-up is complete and power-down is inactive.
- R4: When `pd_in` is high for at least PD_PERIODS+DEGLITCH_CYC consecutive rising edges of `src_clk` (default 2+500), the output stops. `running` is low no later than three edges after that count has been reached.
- R5: A `pd_in` pulse that is high for fewer consecutive rising edges than that threshold has no effect: `running` stays high and pulses keep coming.
- R6: Once an accepted power-down is released, the start-up count restarts from zero. `clk_out` stays low for at least START_CYC cycles and then resumes.
- R7: Every high pulse on `clk_out` begins on a rising edge of `src_clk` and lasts exactly one full source high phase. The gate never produces a shortened pulse.
- R8: `running` is high exactly when the gate is open. While the source clock is high, `clk_out` equals `running`.
- R9: The two controls are independent. With `oe_in` low, releasing power-down and completing start-up do not start the output. The output starts only once `oe_in` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Free-running source clock to be gated |
| rst_n | input | 1 | Active-low power-good reset, asynchronous assert |
| oe_in | input | 1 | Output enable, asynchronous, high lets the clock through |
| pd_in | input | 1 | Power-down request, asynchronous, filtered before use |
| clk_out | output | 1 | Gated clock toward the pin |
| running | output | 1 | High while the gate passes clock pulses |

## Verification
The assertions take `src_clk` to be free-running with both phases nonzero, and `rst_n` to be released away from a rising edge. Under those conditions the negative-edge gate register and the positive-edge control registers settle before they are sampled. The assertions also assume `oe_in` and `pd_in` may change at any time, because the synchronizers absorb them. The stimulus changes the controls and releases reset only one nanosecond after a rising edge, which puts every change well inside a phase. Power-down pulses are timed to an exact number of rising edges, one below the threshold and exactly at it.

// File: rtl/ogate_pkg.sv
package ogate_pkg;

    // Start-up sequencer mode
    typedef enum logic {
        BOOT_COUNT = 1'b0,
        BOOT_DONE  = 1'b1
    } boot_e;

    // Width needed for a counter that reaches limit-1 (at least one bit)
    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/ogate_sync.sv
module ogate_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        sync_t s_d, s_q;

        always_comb begin
            s_d = s_q;
            if (STAGES > 1) begin
                s_d.chain = {s_q.chain[STAGES-2:0], async_in[b]};
            end else begin
                s_d.chain = async_in[b];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_q <= '0;
            end else begin
                s_q <= s_d;
            end
        end

        assign sync_out[b] = s_q.chain[STAGES-1];
    end

endmodule

// File: rtl/ogate_pd_filter.sv
module ogate_pd_filter #(
    parameter int HOLD_CYC = 502
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_sync,
    output logic pd_act,
    output logic pd_exit
);

    localparam int CNT_W = ogate_pkg::cnt_width(HOLD_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] run_cnt;
        logic             act;
    } filt_t;

    filt_t f_d, f_q;
    logic  exit_d;

    always_comb begin
        f_d    = f_q;
        exit_d = 1'b0;
        if (pd_sync) begin
            if (!f_q.act) begin
                if (f_q.run_cnt == LAST) begin
                    f_d.act     = 1'b1;
                    f_d.run_cnt = '0;
                end else begin
                    f_d.run_cnt = f_q.run_cnt + 1'b1;
                end
            end
        end else begin
            f_d.run_cnt = '0;
            if (f_q.act) begin
                f_d.act = 1'b0;
                exit_d  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign pd_act  = f_q.act;
    assign pd_exit = exit_d;

    // Acceptance only follows a high synchronized level
    AST_PD_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_act) |-> $past(pd_sync)); // R5

    // Release reported only when the filter was active
    AST_EXIT_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_exit |-> pd_act); // R6

endmodule

// File: rtl/ogate_startup.sv
module ogate_startup #(
    parameter int START_CYC = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic start_done
);

    import ogate_pkg::*;

    localparam int CNT_W = cnt_width(START_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(START_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        boot_e            mode;
    } boot_t;

    boot_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (restart) begin
            b_d.cnt  = '0;
            b_d.mode = BOOT_COUNT;
        end else if (b_q.mode == BOOT_COUNT) begin
            if (b_q.cnt == LAST) begin
                b_d.mode = BOOT_DONE;
            end else begin
                b_d.cnt = b_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.cnt  <= '0;
            b_q.mode <= BOOT_COUNT;
        end else begin
            b_q <= b_d;
        end
    end

    assign start_done = (b_q.mode == BOOT_DONE);

    // Once complete, start-up stays complete until a restart
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_done && !restart |=> start_done); // R2

    // A restart always reopens the count
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !start_done); // R6

endmodule

// File: rtl/ogate_cell.sv
module ogate_cell (
    input  logic src_clk,
    input  logic rst_n,
    input  logic start_done,
    input  logic pd_act,
    input  logic oe_ok,
    output logic clk_out,
    output logic running
);

    typedef struct packed {
        logic open;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.open = start_done & ~pd_act & oe_ok;
    end

    // Captured while the source is low: the gate moves only between pulses
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign clk_out = src_clk & g_q.open;
    assign running = g_q.open;

    AST_QUIET_IN_BOOT: assert property (@(posedge src_clk) disable iff (!rst_n)
        !start_done |-> !running); // R2

    AST_QUIET_IN_PDOWN: assert property (@(posedge src_clk) disable iff (!rst_n)
        pd_act |-> !running); // R4

    AST_QUIET_NO_OE: assert property (@(posedge src_clk) disable iff (!rst_n)
        !oe_ok |-> !running); // R3

    AST_OPEN_STABLE_HIGH: assert property (@(negedge src_clk) disable iff (!rst_n)
        $rose(running) |-> $past(start_done)); // R7

endmodule

// File: rtl/glitchfree_clk_gate.sv
module glitchfree_clk_gate #(
    parameter int START_CYC    = 512,
    parameter int DEGLITCH_CYC = 500,
    parameter int PD_PERIODS   = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic oe_in,
    input  logic pd_in,
    output logic clk_out,
    output logic running
);

    localparam int PD_HOLD = PD_PERIODS + DEGLITCH_CYC;
    localparam int N_CTRL  = 2;

    logic [N_CTRL-1:0] ctrl_raw;
    logic [N_CTRL-1:0] ctrl_sync;
    logic              pd_act;
    logic              pd_exit;
    logic              start_done;

    assign ctrl_raw = {pd_in, oe_in};

    ogate_sync #(
        .WIDTH  (N_CTRL),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (src_clk),
        .rst_n    (rst_n),
        .async_in (ctrl_raw),
        .sync_out (ctrl_sync)
    );

    ogate_pd_filter #(
        .HOLD_CYC (PD_HOLD)
    ) u_pdf (
        .clk     (src_clk),
        .rst_n   (rst_n),
        .pd_sync (ctrl_sync[1]),
        .pd_act  (pd_act),
        .pd_exit (pd_exit)
    );

    ogate_startup #(
        .START_CYC (START_CYC)
    ) u_boot (
        .clk        (src_clk),
        .rst_n      (rst_n),
        .restart    (pd_exit),
        .start_done (start_done)
    );

    ogate_cell u_cell (
        .src_clk    (src_clk),
        .rst_n      (rst_n),
        .start_done (start_done),
        .pd_act     (pd_act),
        .oe_ok      (ctrl_sync[0]),
        .clk_out    (clk_out),
        .running    (running)
    );

    // Leaving an accepted power-down always reopens start-up
    AST_PDOWN_REBOOTS: assert property (@(posedge src_clk) disable iff (!rst_n)
        $fell(pd_act) |-> !start_done); // R6

endmodule

// File: tb/sim_glitchfree_clk_gate.sv
`timescale 1ns/1ps
module sim_glitchfree_clk_gate;

    localparam int START_CYC = 512;
    localparam int DEGLITCH  = 20;
    localparam int HOLD      = 2 + DEGLITCH;
    localparam int NVEC      = 9;

    // vector: [12] oe, [11] pd, [10] expected running, [9:0] cycles to hold
    localparam logic [12:0] VECS [NVEC] = '{
        {1'b1, 1'b0, 1'b1, 10'd10},
        {1'b0, 1'b0, 1'b0, 10'd10},
        {1'b1, 1'b0, 1'b1, 10'd10},
        {1'b1, 1'b1, 1'b0, 10'd40},
        {1'b1, 1'b0, 1'b0, 10'd10},
        {1'b1, 1'b0, 1'b1, 10'd600},
        {1'b0, 1'b1, 1'b0, 10'd40},
        {1'b0, 1'b0, 1'b0, 10'd600},
        {1'b1, 1'b0, 1'b1, 10'd10}
    };

    logic src_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic oe_in   = 1'b1;
    logic pd_in   = 1'b0;
    wire  clk_out;
    wire  running;

    int checks   = 0;
    int errors   = 0;
    int pulses   = 0;
    int runts    = 0;
    bit finished = 1'b0;
    realtime t_rise = 0.0;

    always #2.5 src_clk = ~src_clk;

    glitchfree_clk_gate #(
        .START_CYC    (START_CYC),
        .DEGLITCH_CYC (DEGLITCH)
    ) u0 (
        .src_clk (src_clk),
        .rst_n   (rst_n),
        .oe_in   (oe_in),
        .pd_in   (pd_in),
        .clk_out (clk_out),
        .running (running)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge src_clk);
        #1;
    endtask

    // R7 pulse-shape monitor
    always @(posedge clk_out) begin
        t_rise = $realtime;
        if (src_clk !== 1'b1) runts++;
    end
    always @(negedge clk_out) begin
        pulses++;
        if (($realtime - t_rise) < 2.49 || ($realtime - t_rise) > 2.51) runts++;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R1 running in reset", running, 1'b0);
        chk("R1 clk_out in reset", clk_out, 1'b0);
        rst_n = 1'b1;

        // R2 exact start-up boundary
        tick(START_CYC - 1);
        chk("R2 running before edge 512", running, 1'b0);
        tick(1);
        chk("R2 clk_out at edge 512", clk_out, 1'b0);
        tick(1);
        chk("R2 running at edge 513", running, 1'b1);
        chk("R8 clk_out at edge 513", clk_out, 1'b1);

        // table walk: R3 R4 R6 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            oe_in = VECS[i][12];
            pd_in = VECS[i][11];
            tick(int'(VECS[i][9:0]));
            chk($sformatf("R3/R4/R6/R9 vector %0d running", i), running, VECS[i][10]);
            chk($sformatf("R8 vector %0d clk_out", i), clk_out, VECS[i][10]);
        end

        // R5 pulse one edge short of the threshold
        begin
            int drops = 0;
            pd_in = 1'b1;
            for (int k = 0; k < HOLD - 1; k++) begin
                tick(1);
                if (running !== 1'b1) drops++;
            end
            pd_in = 1'b0;
            for (int k = 0; k < 10; k++) begin
                tick(1);
                if (running !== 1'b1) drops++;
            end
            chk("R5 short pulse ignored", (drops == 0), 1'b1);
            chk("R5 clk_out after short pulse", clk_out, 1'b1);
        end

        // R4 pulse exactly at the threshold, then R6 restart
        pd_in = 1'b1;
        tick(HOLD);
        pd_in = 1'b0;
        tick(5);
        chk("R4 pulse at threshold stops", running, 1'b0);
        tick(500);
        chk("R6 still counting after release", running, 1'b0);
        chk("R6 clk_out quiet while counting", clk_out, 1'b0);
        tick(12);
        chk("R6 output back after recount", running, 1'b1);

        chk("R7 no shortened pulses", (runts == 0 && pulses > 0), 1'b1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule